// File: doc/BRIEF.md
# Multi-Channel DMA Register Decoder

This block is the register-bus front end of a copy engine that runs several independent DMA channels. One address window is split into a global area (offsets below 0x80) and a 0x80-byte window for each channel that follows it. The block decodes each access by offset and size, returns read data one cycle later, and applies the side effects tied to reads and writes. It holds the per-channel descriptor-chain and completion addresses, control, status and error registers. It also drives one-cycle start, append and reset pulses towards the channel sequencers, which sit outside this block.

Each access is placed in one of the decoded register classes of `reg_sel_e`. The global classes are count, capacity, interrupt control and attention. The channel classes are control, status, chain low, chain high, command, completion low, completion high and error. An access that falls in no class, or that uses the wrong size, lands in the error class. The response path has two conditions: no response, and response in the cycle after a request. The enumerated class is the only state that steers the data path.

Top module: `dma_regfront`

## Requirements
- R1: Window n = addr[ADDR_W-1:7]. Window 0 is global, with count at 0x00, capacity at 0x01, interrupt control at 0x02 and attention at 0x04. Window n ≥ 1 is channel n-1, with control at 0x00, status 0x08, chain 0x10/0x14, command 0x18, completion 0x20/0x24 and error 0x28. A channel index ≥ NUM_CH is an error.
- R2: The count register (1 byte) reads NUM_CH. The capacity register (1 byte) reads the index of the highest set bit of MAX_XFER. Writes to count, capacity and attention are accepted without error and change nothing.
- R3: Attention (4 bytes) collects bits pulsed on attn_set. A read returns the value and clears it.
- R4: Interrupt control (1 byte) bit 0 is the master enable, seen on int_master_en. A write loads only bit 0. A read returns it and then clears it.
- R5: Control (2 bytes) bit 0 is the in-use flag. A read returns the prior value and then sets the flag.
- R6: A control write loads bits 15:0, except bit 1 (interrupt disable). Bit 1 is cleared when written as 1 and otherwise keeps its old value. ch_intdis_set sets bit 1.
- R7: Status (8 bytes) resets to 3 and is loaded by ch_stat_we/ch_stat_data. A read returns it with bit 0 forced to 1 while the channel's ch_busy is low. Writes are ignored.
- R8: The chain and completion registers are 64 bits. An 8-byte write at the low offset replaces all 64 bits. A 4-byte write at the low offset replaces bits 31:0. A 4-byte write at the high offset (+4) replaces bits 63:32. Reads mirror this.
- R9: Error (4 bytes) ORs in ch_err_bits on ch_err_set. A write clears each bit written as 1.
- R10: A 1-byte command write drives, in the next cycle and for one cycle, start (bit 0), else append (bit 1), else reset (bit 2), in that priority. Any of bits 5:3 makes the write an error and no pulse is issued. Command reads return 0.
- R11: An unknown offset or a wrong size gives rsp_err=1 and rsp_rdata=0, and no register changes.
- R12: Every request gets rsp_valid one cycle later. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 2 | 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Decode or size error |
| int_master_en | output | 1 | Master interrupt enable |
| attn_set | input | 32 | Attention bits to set |
| ch_busy | input | NUM_CH | Channel busy flags |
| ch_stat_we | input | NUM_CH | Status load strobes |
| ch_stat_data | input | 64 | Status load value |
| ch_err_set | input | NUM_CH | Error set strobes |
| ch_err_bits | input | 32 | Error bits to set |
| ch_intdis_set | input | NUM_CH | Interrupt-disable set strobes |
| ch_chain_addr | output | NUM_CH*64 | Chain addresses, channel 0 lowest |
| ch_cmpl_addr | output | NUM_CH*64 | Completion addresses |
| ch_start | output | NUM_CH | Start pulses |
| ch_append | output | NUM_CH | Append pulses |
| ch_reset | output | NUM_CH | Reset pulses |

## Verification
A wrong decoded class or channel index shows up in the very next response: wrong read data, a spurious rsp_err, or a pulse on the wrong channel's command line. A lost or doubled side effect stays hidden until the register is accessed again, so each such case is paired with a second read that exposes the changed state. Address-half mistakes are visible at once on the exported address buses, one cycle after the write.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_G_COUNT,
        SEL_G_CAP,
        SEL_G_INTR,
        SEL_G_ATTN,
        SEL_C_CTRL,
        SEL_C_STAT,
        SEL_C_CHAIN_LO,
        SEL_C_CHAIN_HI,
        SEL_C_CMD,
        SEL_C_CMPL_LO,
        SEL_C_CMPL_HI,
        SEL_C_ERR
    } reg_sel_e;

    localparam logic [1:0] SZ_B1 = 2'd0;
    localparam logic [1:0] SZ_B2 = 2'd1;
    localparam logic [1:0] SZ_B4 = 2'd2;
    localparam logic [1:0] SZ_B8 = 2'd3;

    localparam logic [6:0] OFF_G_COUNT    = 7'h00;
    localparam logic [6:0] OFF_G_CAP      = 7'h01;
    localparam logic [6:0] OFF_G_INTR     = 7'h02;
    localparam logic [6:0] OFF_G_ATTN     = 7'h04;

    localparam logic [6:0] OFF_C_CTRL     = 7'h00;
    localparam logic [6:0] OFF_C_STAT     = 7'h08;
    localparam logic [6:0] OFF_C_CHAIN_LO = 7'h10;
    localparam logic [6:0] OFF_C_CHAIN_HI = 7'h14;
    localparam logic [6:0] OFF_C_CMD      = 7'h18;
    localparam logic [6:0] OFF_C_CMPL_LO  = 7'h20;
    localparam logic [6:0] OFF_C_CMPL_HI  = 7'h24;
    localparam logic [6:0] OFF_C_ERR      = 7'h28;

    localparam int CTRL_INUSE  = 0;
    localparam int CTRL_INTDIS = 1;

    localparam int CMD_START  = 0;
    localparam int CMD_APPEND = 1;
    localparam int CMD_RESET  = 2;
    localparam logic [7:0] CMD_UNSUP_MASK = 8'h38;

    localparam logic [63:0] STAT_RESET = 64'h3;

    function automatic int msb_index(input int unsigned v);
        int r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/dma_regfront_decode.sv
module dma_regfront_decode
    import dma_regfront_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 14,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic [7:0]        wbyte,
    output reg_sel_e          sel,
    output logic [CH_W-1:0]   chan,
    output logic              is_chan,
    output logic              full,
    output logic              bad
);

    localparam int WIN_W = ADDR_W - 7;

    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] win_m1;
    logic [6:0]       off;
    logic             size_ok;
    logic             chan_ok;
    logic             cmd_unsup;

    assign win     = addr[ADDR_W-1:7];
    assign off     = addr[6:0];
    assign win_m1  = win - WIN_W'(1);
    assign is_chan = (win != '0);
    assign chan_ok = win_m1 < WIN_W'(NUM_CH);
    assign chan    = win_m1[CH_W-1:0];
    assign full    = (size == SZ_B8);

    always_comb begin
        sel       = SEL_NONE;
        size_ok   = 1'b0;
        cmd_unsup = 1'b0;
        if (!is_chan) begin
            unique case (off)
                OFF_G_COUNT: begin sel = SEL_G_COUNT; size_ok = (size == SZ_B1); end
                OFF_G_CAP:   begin sel = SEL_G_CAP;   size_ok = (size == SZ_B1); end
                OFF_G_INTR:  begin sel = SEL_G_INTR;  size_ok = (size == SZ_B1); end
                OFF_G_ATTN:  begin sel = SEL_G_ATTN;  size_ok = (size == SZ_B4); end
                default:     sel = SEL_NONE;
            endcase
        end else begin
            unique case (off)
                OFF_C_CTRL:     begin sel = SEL_C_CTRL;     size_ok = (size == SZ_B2); end
                OFF_C_STAT:     begin sel = SEL_C_STAT;     size_ok = (size == SZ_B8); end
                OFF_C_CHAIN_LO: begin sel = SEL_C_CHAIN_LO; size_ok = (size == SZ_B4) || (size == SZ_B8); end
                OFF_C_CHAIN_HI: begin sel = SEL_C_CHAIN_HI; size_ok = (size == SZ_B4); end
                OFF_C_CMD: begin
                    sel       = SEL_C_CMD;
                    size_ok   = (size == SZ_B1);
                    cmd_unsup = write && ((wbyte & CMD_UNSUP_MASK) != 8'h00);
                end
                OFF_C_CMPL_LO:  begin sel = SEL_C_CMPL_LO;  size_ok = (size == SZ_B4) || (size == SZ_B8); end
                OFF_C_CMPL_HI:  begin sel = SEL_C_CMPL_HI;  size_ok = (size == SZ_B4); end
                OFF_C_ERR:      begin sel = SEL_C_ERR;      size_ok = (size == SZ_B4); end
                default:        sel = SEL_NONE;
            endcase
        end
    end

    assign bad = (sel == SEL_NONE) || !size_ok || (is_chan && !chan_ok) || cmd_unsup;

endmodule

// File: rtl/dma_regfront_chan.sv
module dma_regfront_chan
    import dma_regfront_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  reg_sel_e    sel,
    input  logic        full,
    input  logic [63:0] wdata,
    input  logic        busy,
    input  logic        stat_we,
    input  logic [63:0] stat_data,
    input  logic        err_set,
    input  logic [31:0] err_bits,
    input  logic        intdis_set,
    output logic [63:0] rd_val,
    output logic [63:0] chain_q,
    output logic [63:0] cmpl_q,
    output logic        start_p,
    output logic        append_p,
    output logic        reset_p
);

    logic [15:0] ctrl_q, ctrl_d;
    logic [63:0] stat_q;
    logic [31:0] err_q, err_d;
    logic [63:0] chain_d, cmpl_d;
    logic        cmd_wr;

    assign cmd_wr = acc_wr && (sel == SEL_C_CMD);

    always_comb begin
        ctrl_d  = ctrl_q;
        err_d   = err_q;
        chain_d = chain_q;
        cmpl_d  = cmpl_q;
        if (acc_wr) begin
            unique case (sel)
                SEL_C_CTRL: begin
                    ctrl_d = wdata[15:0];
                    ctrl_d[CTRL_INTDIS] = wdata[CTRL_INTDIS] ? 1'b0 : ctrl_q[CTRL_INTDIS];
                end
                SEL_C_CHAIN_LO: chain_d = full ? wdata : {chain_q[63:32], wdata[31:0]};
                SEL_C_CHAIN_HI: chain_d = {wdata[31:0], chain_q[31:0]};
                SEL_C_CMPL_LO:  cmpl_d  = full ? wdata : {cmpl_q[63:32], wdata[31:0]};
                SEL_C_CMPL_HI:  cmpl_d  = {wdata[31:0], cmpl_q[31:0]};
                SEL_C_ERR:      err_d   = err_q & ~wdata[31:0];
                default: ;
            endcase
        end
        if (acc_rd && (sel == SEL_C_CTRL)) ctrl_d[CTRL_INUSE] = 1'b1;
        if (intdis_set) ctrl_d[CTRL_INTDIS] = 1'b1;
        if (err_set) err_d = err_d | err_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            stat_q   <= STAT_RESET;
            err_q    <= '0;
            chain_q  <= '0;
            cmpl_q   <= '0;
            start_p  <= 1'b0;
            append_p <= 1'b0;
            reset_p  <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            err_q    <= err_d;
            chain_q  <= chain_d;
            cmpl_q   <= cmpl_d;
            if (stat_we) stat_q <= stat_data;
            start_p  <= cmd_wr && wdata[CMD_START];
            append_p <= cmd_wr && !wdata[CMD_START] && wdata[CMD_APPEND];
            reset_p  <= cmd_wr && !wdata[CMD_START] && !wdata[CMD_APPEND] && wdata[CMD_RESET];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_C_CTRL:     rd_val = {48'b0, ctrl_q};
            SEL_C_STAT:     rd_val = stat_q | {63'b0, ~busy};
            SEL_C_CHAIN_LO: rd_val = full ? chain_q : {32'b0, chain_q[31:0]};
            SEL_C_CHAIN_HI: rd_val = {32'b0, chain_q[63:32]};
            SEL_C_CMPL_LO:  rd_val = full ? cmpl_q : {32'b0, cmpl_q[31:0]};
            SEL_C_CMPL_HI:  rd_val = {32'b0, cmpl_q[63:32]};
            SEL_C_ERR:      rd_val = {32'b0, err_q};
            default:        rd_val = '0;
        endcase
    end

endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
    import dma_regfront_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter int unsigned MAX_XFER = 3000,
    parameter int          ADDR_W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [63:0]         req_wdata,
    output logic                rsp_valid,
    output logic [63:0]         rsp_rdata,
    output logic                rsp_err,
    output logic                int_master_en,
    input  logic [31:0]         attn_set,
    input  logic [NUM_CH-1:0]   ch_busy,
    input  logic [NUM_CH-1:0]   ch_stat_we,
    input  logic [63:0]         ch_stat_data,
    input  logic [NUM_CH-1:0]   ch_err_set,
    input  logic [31:0]         ch_err_bits,
    input  logic [NUM_CH-1:0]   ch_intdis_set,
    output logic [NUM_CH*64-1:0] ch_chain_addr,
    output logic [NUM_CH*64-1:0] ch_cmpl_addr,
    output logic [NUM_CH-1:0]   ch_start,
    output logic [NUM_CH-1:0]   ch_append,
    output logic [NUM_CH-1:0]   ch_reset
);

    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CAP_IDX = msb_index(MAX_XFER);

    reg_sel_e          sel;
    logic [CH_W-1:0]   chan;
    logic              is_chan;
    logic              full;
    logic              bad;
    logic              acc_ok;
    logic              g_rd, g_wr;
    logic [31:0]       attn_q, attn_d;
    logic              int_en_q;
    logic [63:0]       ch_rd [NUM_CH];
    logic [63:0]       rd_ch;
    logic [63:0]       rd_val;

    dma_regfront_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_decode (
        .addr    (req_addr),
        .size    (req_size),
        .write   (req_write),
        .wbyte   (req_wdata[7:0]),
        .sel     (sel),
        .chan    (chan),
        .is_chan (is_chan),
        .full    (full),
        .bad     (bad)
    );

    assign acc_ok = req_valid && !bad;
    assign g_rd   = acc_ok && !is_chan && !req_write;
    assign g_wr   = acc_ok && !is_chan && req_write;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = acc_ok && is_chan && (chan == CH_W'(i));
        dma_regfront_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_rd     (hit && !req_write),
            .acc_wr     (hit && req_write),
            .sel        (sel),
            .full       (full),
            .wdata      (req_wdata),
            .busy       (ch_busy[i]),
            .stat_we    (ch_stat_we[i]),
            .stat_data  (ch_stat_data),
            .err_set    (ch_err_set[i]),
            .err_bits   (ch_err_bits),
            .intdis_set (ch_intdis_set[i]),
            .rd_val     (ch_rd[i]),
            .chain_q    (ch_chain_addr[i*64 +: 64]),
            .cmpl_q     (ch_cmpl_addr[i*64 +: 64]),
            .start_p    (ch_start[i]),
            .append_p   (ch_append[i]),
            .reset_p    (ch_reset[i])
        );
    end

    // Global registers: attention collects and clears on read, enable clears on read.
    always_comb begin
        attn_d = attn_q;
        if (g_rd && (sel == SEL_G_ATTN)) attn_d = '0;
        attn_d = attn_d | attn_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attn_q   <= '0;
            int_en_q <= 1'b0;
        end else begin
            attn_q <= attn_d;
            if (g_wr && (sel == SEL_G_INTR))      int_en_q <= req_wdata[0];
            else if (g_rd && (sel == SEL_G_INTR)) int_en_q <= 1'b0;
        end
    end

    assign int_master_en = int_en_q;

    always_comb begin
        rd_ch = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan == CH_W'(i)) rd_ch = ch_rd[i];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_G_COUNT: rd_val = {56'b0, 8'(NUM_CH)};
            SEL_G_CAP:   rd_val = {56'b0, 8'(CAP_IDX)};
            SEL_G_INTR:  rd_val = {63'b0, int_en_q};
            SEL_G_ATTN:  rd_val = {32'b0, attn_q};
            SEL_NONE:    rd_val = '0;
            default:     rd_val = rd_ch;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && bad;
            rsp_rdata <= (acc_ok && !req_write) ? rd_val : 64'h0;
        end
    end

endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [1:0]           req_size,
    input logic                 rsp_valid,
    input logic [63:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic                 int_master_en,
    input logic [NUM_CH*64-1:0] ch_chain_addr,
    input logic [NUM_CH-1:0]    ch_start,
    input logic [NUM_CH-1:0]    ch_append,
    input logic [NUM_CH-1:0]    ch_reset
);

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'h0));

    // R10
    one_cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_start, ch_append, ch_reset}));

    // R10
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{ch_start, ch_append, ch_reset}) |-> $past(req_valid && req_write && (req_size == 2'd0)));

    // R8
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(req_valid && req_write)) |-> $stable(ch_chain_addr));

    // R4
    intr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr == ADDR_W'(2)) && (req_size == 2'd0)) |=> !int_master_en);

endmodule

bind dma_regfront dma_regfront_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err),
    .int_master_en (int_master_en),
    .ch_chain_addr (ch_chain_addr),
    .ch_start      (ch_start),
    .ch_append     (ch_append),
    .ch_reset      (ch_reset)
);

// File: tb/dma_regfront_bench.sv
module dma_regfront_bench;

    localparam int PERIOD = 10;
    localparam int NCH    = 4;
    localparam int AW     = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              rsp_err;
    logic              int_master_en;
    logic [31:0]       attn_set = '0;
    logic [NCH-1:0]    ch_busy = '0;
    logic [NCH-1:0]    ch_stat_we = '0;
    logic [63:0]       ch_stat_data = '0;
    logic [NCH-1:0]    ch_err_set = '0;
    logic [31:0]       ch_err_bits = '0;
    logic [NCH-1:0]    ch_intdis_set = '0;
    logic [NCH*64-1:0] ch_chain_addr;
    logic [NCH*64-1:0] ch_cmpl_addr;
    logic [NCH-1:0]    ch_start, ch_append, ch_reset;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0]    r_data;
    logic           r_err;
    logic [NCH-1:0] r_start, r_append, r_reset;

    always #(PERIOD/2) clk = ~clk;

    dma_regfront #(.NUM_CH(NCH), .MAX_XFER(3000), .ADDR_W(AW)) u_dma_regfront (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .int_master_en(int_master_en), .attn_set(attn_set), .ch_busy(ch_busy),
        .ch_stat_we(ch_stat_we), .ch_stat_data(ch_stat_data), .ch_err_set(ch_err_set),
        .ch_err_bits(ch_err_bits), .ch_intdis_set(ch_intdis_set),
        .ch_chain_addr(ch_chain_addr), .ch_cmpl_addr(ch_cmpl_addr),
        .ch_start(ch_start), .ch_append(ch_append), .ch_reset(ch_reset)
    );

    function automatic logic [AW-1:0] cb(input int c, input int off);
        return AW'((c + 1) * 128 + off);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        chk("R12 rsp_valid", {63'b0, rsp_valid}, 64'd1);
        r_data = rsp_rdata; r_err = rsp_err;
        r_start = ch_start; r_append = ch_append; r_reset = ch_reset;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 idle rsp", {63'b0, rsp_valid}, 64'd0);
        chk("R4 reset enable", {63'b0, int_master_en}, 64'd0);
        chk("R8 reset chain", ch_chain_addr[63:0], 64'd0);
    endtask

    task automatic t_global;
        acc(0, AW'(0), 2'd0, 0);  chk("R2 count", r_data, 64'd4);
        chk("R1 global ok", {63'b0, r_err}, 64'd0);
        acc(0, AW'(1), 2'd0, 0);  chk("R2 capacity", r_data, 64'd11);
        acc(1, AW'(0), 2'd0, 64'h55); chk("R2 count write err", {63'b0, r_err}, 64'd0);
        acc(0, AW'(0), 2'd0, 0);  chk("R2 count kept", r_data, 64'd4);
    endtask

    task automatic t_attn;
        @(negedge clk); attn_set = 32'h5;
        @(negedge clk); attn_set = 32'h0;
        acc(0, AW'(4), 2'd2, 0); chk("R3 attn read", r_data, 64'h5);
        acc(0, AW'(4), 2'd2, 0); chk("R3 attn cleared", r_data, 64'h0);
        @(negedge clk); attn_set = 32'h9;
        @(negedge clk); attn_set = 32'h0;
        acc(1, AW'(4), 2'd2, 64'hFF); chk("R2 attn write err", {63'b0, r_err}, 64'd0);
        acc(0, AW'(4), 2'd2, 0); chk("R2 attn write ignored", r_data, 64'h9);
    endtask

    task automatic t_intr;
        acc(1, AW'(2), 2'd0, 64'h01); chk("R4 enable set", {63'b0, int_master_en}, 64'd1);
        acc(0, AW'(2), 2'd0, 0);      chk("R4 read value", r_data, 64'd1);
        chk("R4 cleared by read", {63'b0, int_master_en}, 64'd0);
        acc(0, AW'(2), 2'd0, 0);      chk("R4 second read", r_data, 64'd0);
        acc(1, AW'(2), 2'd0, 64'hFE); chk("R4 only bit0", {63'b0, int_master_en}, 64'd0);
    endtask

    task automatic t_ctrl;
        acc(0, cb(1, 'h00), 2'd1, 0); chk("R5 first read", r_data, 64'h0);
        acc(0, cb(1, 'h00), 2'd1, 0); chk("R5 in-use set", r_data, 64'h1);
        @(negedge clk); ch_intdis_set = 4'b0010;
        @(negedge clk); ch_intdis_set = 4'b0000;
        acc(1, cb(1, 'h00), 2'd1, 64'hF0F0);
        acc(0, cb(1, 'h00), 2'd1, 0); chk("R6 disable kept", r_data, 64'hF0F2);
        acc(1, cb(1, 'h00), 2'd1, 64'h0002);
        acc(0, cb(1, 'h00), 2'd1, 0); chk("R6 disable cleared", r_data, 64'h0000);
    endtask

    task automatic t_status;
        acc(0, cb(2, 'h08), 2'd3, 0); chk("R7 reset status", r_data, 64'h3);
        @(negedge clk); ch_stat_we = 4'b0100; ch_stat_data = 64'hA0;
        @(negedge clk); ch_stat_we = 4'b0000;
        acc(0, cb(2, 'h08), 2'd3, 0); chk("R7 idle bit forced", r_data, 64'hA1);
        ch_busy = 4'b0100;
        acc(0, cb(2, 'h08), 2'd3, 0); chk("R7 busy no force", r_data, 64'hA0);
        acc(1, cb(2, 'h08), 2'd3, 64'hFFFF);
        acc(0, cb(2, 'h08), 2'd3, 0); chk("R7 write ignored", r_data, 64'hA0);
        ch_busy = 4'b0000;
    endtask

    task automatic t_addr;
        acc(1, cb(0, 'h10), 2'd3, 64'h1111_2222_3333_4444);
        chk("R8 full write", ch_chain_addr[63:0], 64'h1111_2222_3333_4444);
        acc(1, cb(0, 'h10), 2'd2, 64'hAAAA_BBBB);
        chk("R8 low half", ch_chain_addr[63:0], 64'h1111_2222_AAAA_BBBB);
        acc(1, cb(0, 'h14), 2'd2, 64'hCCCC_DDDD);
        chk("R8 high half", ch_chain_addr[63:0], 64'hCCCC_DDDD_AAAA_BBBB);
        acc(0, cb(0, 'h14), 2'd2, 0); chk("R8 read high", r_data, 64'hCCCC_DDDD);
        acc(0, cb(0, 'h10), 2'd2, 0); chk("R8 read low", r_data, 64'hAAAA_BBBB);
        acc(1, cb(3, 'h24), 2'd2, 64'h1234_5678);
        acc(1, cb(3, 'h20), 2'd2, 64'h9ABC_DEF0);
        chk("R8 completion", ch_cmpl_addr[255:192], 64'h1234_5678_9ABC_DEF0);
        acc(0, cb(3, 'h20), 2'd3, 0); chk("R8 read completion", r_data, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_err;
        @(negedge clk); ch_err_set = 4'b0001; ch_err_bits = 32'hF0;
        @(negedge clk); ch_err_set = 4'b0000;
        acc(1, cb(0, 'h28), 2'd2, 64'h30);
        acc(0, cb(0, 'h28), 2'd2, 0); chk("R9 w1c", r_data, 64'hC0);
    endtask

    task automatic t_cmd;
        acc(1, cb(2, 'h18), 2'd0, 64'h01); chk("R10 start", {60'b0, r_start}, 64'h4);
        chk("R10 start only", {56'b0, r_append, r_reset}, 64'h0);
        acc(1, cb(2, 'h18), 2'd0, 64'h03); chk("R10 start priority", {52'b0, r_start, r_append, r_reset}, 64'h400);
        acc(1, cb(2, 'h18), 2'd0, 64'h06); chk("R10 append", {52'b0, r_start, r_append, r_reset}, 64'h040);
        acc(1, cb(2, 'h18), 2'd0, 64'h04); chk("R10 reset", {52'b0, r_start, r_append, r_reset}, 64'h004);
        acc(1, cb(2, 'h18), 2'd0, 64'h09); chk("R10 unsupported err", {63'b0, r_err}, 64'd1);
        chk("R10 unsupported no pulse", {52'b0, r_start, r_append, r_reset}, 64'h0);
        acc(0, cb(2, 'h18), 2'd0, 0); chk("R10 read zero", r_data, 64'h0);
    endtask

    task automatic t_bad;
        acc(0, AW'(3), 2'd0, 0);       chk("R11 unknown global", {r_data[62:0], r_err}, 64'd1);
        acc(0, AW'(0), 2'd1, 0);       chk("R11 wrong size", {63'b0, r_err}, 64'd1);
        acc(0, cb(4, 'h00), 2'd1, 0);  chk("R1 channel range", {63'b0, r_err}, 64'd1);
        acc(1, cb(0, 'h14), 2'd3, 64'hDEAD);
        chk("R11 bad size write err", {63'b0, r_err}, 64'd1);
        chk("R11 chain unchanged", ch_chain_addr[63:0], 64'hCCCC_DDDD_AAAA_BBBB);
        acc(0, cb(0, 'h30), 2'd2, 0);  chk("R11 unknown channel reg", {r_data[62:0], r_err}, 64'd1);
        acc(0, cb(3, 'h10), 2'd3, 0);  chk("R1 last channel", {63'b0, r_err}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_global;
        t_attn;
        t_intr;
        t_ctrl;
        t_status;
        t_addr;
        t_err;
        t_cmd;
        t_bad;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule